// File: doc/BRIEF.md
# Shift, Rotate and Sign-Test Execute Unit

This block is the execute stage for one instruction group of a 16-bit-opcode RISC core that keeps a single condition bit, T. It takes an opcode, one 32-bit register operand and the current T. It produces a new register value, a new T value, a write enable for each, and a flag for an undefined code within the group. The operations are one-bit shifts and rotates that send the bit shifted out into T, rotates that pass through T, fixed shifts by 2, 8 or 16 positions, and two tests of the operand's sign against zero that change only T.

The decode and the datapath are combinational. A thin registered top samples them on an input strobe and presents the outcome one clock later, together with an output strobe. The pipeline uses the two enables to decide whether to write the register file and T. Operand fetch, register write-back, memory forms and other opcode groups belong to other blocks.

Top module: `shift_rot_cmp_unit`

## Requirements
- R1: The group is selected only when opcode[15:12] == 4'b0100. With any other value in those bits, both write enables and the illegal flag are 0. Within the group, opcode[5:0] chooses the operation.
- R2: Code 6'h04 rotates the operand left by one and 6'h05 rotates it right by one. The bit that wraps around also becomes T. Both enables are 1.
- R3: Code 6'h24 rotates left by one through T, and 6'h25 rotates right by one through T. The old T fills the vacated end and the bit pushed out becomes T. Both enables are 1.
- R4: Code 6'h01 is a logical right shift by one and 6'h21 is an arithmetic right shift by one. Code 6'h20 is a left shift by one. In each case the bit shifted out becomes T and both enables are 1.
- R5: Code 6'h08 shifts left by 2, 6'h09 shifts right by 2, 6'h18 shifts left by 8 and 6'h29 shifts right by 16. Vacated bits are zero. The result enable is 1, the T enable is 0 and T passes through.
- R6: Code 6'h11 makes T equal to 1 when the operand, read as a two's-complement value, is zero or positive, and 0 otherwise. The T enable is 1 and the result enable is 0.
- R7: Code 6'h15 makes T equal to 1 only when the operand is strictly positive as a signed value, and 0 otherwise. The T enable is 1 and the result enable is 0.
- R8: Any other 6-bit code within the group raises the illegal flag with both enables at 0.
- R9: When the result enable is 0, the result equals the operand. When the T enable is 0, the T output equals the incoming T.
- R10: Inputs are sampled on a clock edge where inValid is 1 and appear on the outputs after that edge with outValid = 1. After an edge where inValid is 0, outValid, both enables and the illegal flag are 0, and result and tOut keep their previous values.
- R11: While rstN is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands valid this cycle |
| opcode | input | 16 | Instruction word |
| rnIn | input | 32 | Register operand |
| tIn | input | 1 | Current T flag |
| outValid | output | 1 | Registered outcome valid |
| result | output | 32 | New register value |
| resultWe | output | 1 | Register write enable |
| tOut | output | 1 | New T value |
| tWe | output | 1 | T write enable |
| illegal | output | 1 | Undefined code within the group |

## Verification
The bench builds the unit with its default 32-bit data width and 16-bit opcode. At that width the shift by 16 moves the upper half exactly into the lower half, and the arithmetic shift and the sign tests reach bit 31. The operands include 0, 1, the most negative and most positive values, all ones and mixed patterns, each with T at 0 and at 1. This exercises the wrap-around bit, the carry-in through T and the zero/positive boundary of both sign tests. Idle cycles are placed between operations so that the hold rule and the clearing of the strobes are observed.

// File: rtl/shift_rot_cmp_pkg.sv
package shift_rot_cmp_pkg;

  typedef enum logic [3:0] {
    OP_NONE, OP_ROTL, OP_ROTR, OP_ROTCL, OP_ROTCR,
    OP_SHLR, OP_SHAR, OP_SHAL,
    OP_SHL2, OP_SHR2, OP_SHL8, OP_SHR16,
    OP_SGEZ, OP_SGTZ
  } opKindT;

  typedef struct packed {
    opKindT kind;
    logic   resultWe;
    logic   tWe;
    logic   illegal;
  } ctrlT;

endpackage

// File: rtl/shift_rot_cmp_ctrl.sv
module shift_rot_cmp_ctrl
  import shift_rot_cmp_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic [OP_W-1:0] opcode,
  output ctrlT            ctrl
);
  localparam logic [3:0] GROUP_ID = 4'b0100;

  logic       inGroup;
  logic [5:0] code;

  assign inGroup = (opcode[OP_W-1 -: 4] == GROUP_ID);
  assign code    = opcode[5:0];

  always_comb begin
    ctrl = '{kind: OP_NONE, resultWe: 1'b0, tWe: 1'b0, illegal: 1'b0};
    if (inGroup) begin
      unique case (code)
        6'h04: ctrl = '{OP_ROTL,  1'b1, 1'b1, 1'b0};
        6'h05: ctrl = '{OP_ROTR,  1'b1, 1'b1, 1'b0};
        6'h24: ctrl = '{OP_ROTCL, 1'b1, 1'b1, 1'b0};
        6'h25: ctrl = '{OP_ROTCR, 1'b1, 1'b1, 1'b0};
        6'h01: ctrl = '{OP_SHLR,  1'b1, 1'b1, 1'b0};
        6'h21: ctrl = '{OP_SHAR,  1'b1, 1'b1, 1'b0};
        6'h20: ctrl = '{OP_SHAL,  1'b1, 1'b1, 1'b0};
        6'h08: ctrl = '{OP_SHL2,  1'b1, 1'b0, 1'b0};
        6'h09: ctrl = '{OP_SHR2,  1'b1, 1'b0, 1'b0};
        6'h18: ctrl = '{OP_SHL8,  1'b1, 1'b0, 1'b0};
        6'h29: ctrl = '{OP_SHR16, 1'b1, 1'b0, 1'b0};
        6'h11: ctrl = '{OP_SGEZ,  1'b0, 1'b1, 1'b0};
        6'h15: ctrl = '{OP_SGTZ,  1'b0, 1'b1, 1'b0};
        default: ctrl = '{OP_NONE, 1'b0, 1'b0, 1'b1};
      endcase
    end
  end
endmodule

// File: rtl/shift_rot_cmp_dp.sv
module shift_rot_cmp_dp
  import shift_rot_cmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  opKindT            kind,
  input  logic [DATA_W-1:0] rn,
  input  logic              tIn,
  output logic [DATA_W-1:0] res,
  output logic              tNew
);
  localparam int MSB   = DATA_W - 1;
  localparam int SH_SM = 2;
  localparam int SH_MD = 8;
  localparam int SH_LG = 16;

  logic signBit, isZero;
  assign signBit = rn[MSB];
  assign isZero  = (rn == '0);

  always_comb begin
    res  = rn;
    tNew = tIn;
    unique case (kind)
      OP_ROTL:  begin res = {rn[MSB-1:0], rn[MSB]};  tNew = rn[MSB]; end
      OP_ROTR:  begin res = {rn[0], rn[MSB:1]};      tNew = rn[0];   end
      OP_ROTCL: begin res = {rn[MSB-1:0], tIn};      tNew = rn[MSB]; end
      OP_ROTCR: begin res = {tIn, rn[MSB:1]};        tNew = rn[0];   end
      OP_SHLR:  begin res = {1'b0, rn[MSB:1]};       tNew = rn[0];   end
      OP_SHAR:  begin res = {rn[MSB], rn[MSB:1]};    tNew = rn[0];   end
      OP_SHAL:  begin res = {rn[MSB-1:0], 1'b0};     tNew = rn[MSB]; end
      OP_SHL2:  res = rn << SH_SM;
      OP_SHR2:  res = rn >> SH_SM;
      OP_SHL8:  res = rn << SH_MD;
      OP_SHR16: res = rn >> SH_LG;
      OP_SGEZ:  tNew = ~signBit;
      OP_SGTZ:  tNew = ~signBit & ~isZero;
      default:  ;
    endcase
  end
endmodule

// File: rtl/shift_rot_cmp_unit.sv
module shift_rot_cmp_unit
  import shift_rot_cmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] rnIn,
  input  logic              tIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic              tOut,
  output logic              tWe,
  output logic              illegal
);
  ctrlT              ctrl;
  logic [DATA_W-1:0] dpRes;
  logic              dpT;

  shift_rot_cmp_ctrl #(.OP_W(OP_W)) u_ctrl (
    .opcode(opcode),
    .ctrl  (ctrl)
  );

  shift_rot_cmp_dp #(.DATA_W(DATA_W)) u_dp (
    .kind(ctrl.kind),
    .rn  (rnIn),
    .tIn (tIn),
    .res (dpRes),
    .tNew(dpT)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      resultWe <= 1'b0;
      tOut     <= 1'b0;
      tWe      <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      resultWe <= inValid & ctrl.resultWe;
      tWe      <= inValid & ctrl.tWe;
      illegal  <= inValid & ctrl.illegal;
      if (inValid) begin
        result <= dpRes;
        tOut   <= dpT;
      end
    end
  end
endmodule

// File: rtl/shift_rot_cmp_chk.sv
module shift_rot_cmp_chk #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OP_W-1:0]   opcode,
  input logic [DATA_W-1:0] rnIn,
  input logic              tIn,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              resultWe,
  input logic              tOut,
  input logic              tWe,
  input logic              illegal
);
  logic grp;
  assign grp = (opcode[OP_W-1 -: 4] == 4'b0100);

  p_idle_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !resultWe && !tWe && !illegal));

  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(tOut)));

  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!resultWe && !tWe && outValid));

  p_outside_group_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !grp) |=> (!resultWe && !tWe && !illegal));

  p_rotl_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && grp && opcode[5:0] == 6'h04) |=>
      (result == {$past(rnIn[DATA_W-2:0]), $past(rnIn[DATA_W-1])}
       && tOut == $past(rnIn[DATA_W-1])));

  p_rotcr_carry_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && grp && opcode[5:0] == 6'h25) |=>
      (result == {$past(tIn), $past(rnIn[DATA_W-1:1])} && tOut == $past(rnIn[0])));

  p_sgez_only_t_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && grp && opcode[5:0] == 6'h11) |=>
      (tWe && !resultWe && tOut == !$past(rnIn[DATA_W-1])));

  p_pass_through_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !grp) |=> (result == $past(rnIn) && tOut == $past(tIn)));
endmodule

bind shift_rot_cmp_unit shift_rot_cmp_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .rnIn(rnIn),
  .tIn(tIn), .outValid(outValid), .result(result), .resultWe(resultWe),
  .tOut(tOut), .tWe(tWe), .illegal(illegal)
);

// File: tb/tb_shift_rot_cmp_unit.sv
`timescale 1ns/1ps
module tb_shift_rot_cmp_unit;
  localparam int W = 32;

  typedef struct {
    logic         vld;
    logic [W-1:0] res;
    logic         rWe;
    logic         tv;
    logic         tWe;
    logic         ill;
    string        tag;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] opcode = '0;
  logic [W-1:0] rnIn = '0;
  logic tIn = 1'b0;
  logic outValid, resultWe, tOut, tWe, illegal;
  logic [W-1:0] result;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  expT q[$];
  logic [W-1:0] lastRes = '0;
  logic lastT = 1'b0;

  always #2.5 clk = ~clk;

  shift_rot_cmp_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .rnIn(rnIn),
    .tIn(tIn), .outValid(outValid), .result(result), .resultWe(resultWe),
    .tOut(tOut), .tWe(tWe), .illegal(illegal)
  );

  function automatic expT model(input logic [15:0] op, input logic [W-1:0] rn, input logic t);
    expT e;
    e.vld = 1'b1; e.res = rn; e.tv = t; e.rWe = 1'b0; e.tWe = 1'b0; e.ill = 1'b0; e.tag = "R9";
    if (op[15:12] != 4'b0100) begin
      e.tag = "R1";
      return e;
    end
    case (op[5:0])
      6'h04: begin e.res = (rn << 1) | (rn >> (W-1)); e.tv = rn[W-1]; e.rWe = 1; e.tWe = 1; e.tag = "R2"; end
      6'h05: begin e.res = (rn >> 1) | (rn << (W-1)); e.tv = rn[0]; e.rWe = 1; e.tWe = 1; e.tag = "R2"; end
      6'h24: begin e.res = (rn << 1) | W'(t); e.tv = rn[W-1]; e.rWe = 1; e.tWe = 1; e.tag = "R3"; end
      6'h25: begin e.res = (rn >> 1) | (W'(t) << (W-1)); e.tv = rn[0]; e.rWe = 1; e.tWe = 1; e.tag = "R3"; end
      6'h01: begin e.res = rn >> 1; e.tv = rn[0]; e.rWe = 1; e.tWe = 1; e.tag = "R4"; end
      6'h21: begin e.res = W'($signed(rn) >>> 1); e.tv = rn[0]; e.rWe = 1; e.tWe = 1; e.tag = "R4"; end
      6'h20: begin e.res = rn << 1; e.tv = rn[W-1]; e.rWe = 1; e.tWe = 1; e.tag = "R4"; end
      6'h08: begin e.res = rn << 2;  e.rWe = 1; e.tag = "R5"; end
      6'h09: begin e.res = rn >> 2;  e.rWe = 1; e.tag = "R5"; end
      6'h18: begin e.res = rn << 8;  e.rWe = 1; e.tag = "R5"; end
      6'h29: begin e.res = rn >> 16; e.rWe = 1; e.tag = "R5"; end
      6'h11: begin e.tv = ($signed(rn) >= 0); e.tWe = 1; e.tag = "R6"; end
      6'h15: begin e.tv = ($signed(rn) > 0);  e.tWe = 1; e.tag = "R7"; end
      default: begin e.ill = 1; e.tag = "R8"; end
    endcase
    return e;
  endfunction

  task automatic applyOp(input logic [15:0] op, input logic [W-1:0] rn, input logic t);
    expT e;
    @(negedge clk);
    inValid = 1'b1; opcode = op; rnIn = rn; tIn = t;
    e = model(op, rn, t);
    lastRes = e.res; lastT = e.tv;
    q.push_back(e);
  endtask

  task automatic idleCycle();
    expT e;
    @(negedge clk);
    inValid = 1'b0; opcode = $urandom; rnIn = $urandom; tIn = ~tIn;
    e.vld = 0; e.res = lastRes; e.tv = lastT; e.rWe = 0; e.tWe = 0; e.ill = 0; e.tag = "R10";
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && q.size() > 0) begin
      expT e;
      e = q.pop_front();
      nChecks++;
      if (outValid !== e.vld || result !== e.res || resultWe !== e.rWe ||
          tOut !== e.tv || tWe !== e.tWe || illegal !== e.ill) begin
        nFails++;
        $display("FAIL %s: act vld=%b res=%h rWe=%b t=%b tWe=%b ill=%b exp vld=%b res=%h rWe=%b t=%b tWe=%b ill=%b",
                 e.tag, outValid, result, resultWe, tOut, tWe, illegal,
                 e.vld, e.res, e.rWe, e.tv, e.tWe, e.ill);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: act running exp finished");
    finishRun();
  end

  initial begin
    logic [5:0] codes[13] = '{6'h04, 6'h05, 6'h24, 6'h25, 6'h01, 6'h21, 6'h20,
                              6'h08, 6'h09, 6'h18, 6'h29, 6'h11, 6'h15};
    logic [W-1:0] pats[7] = '{32'h0, 32'h1, 32'h8000_0000, 32'hFFFF_FFFF,
                              32'h7FFF_FFFF, 32'hA5A5_3C3C, 32'h1234_5678};
    logic [5:0] badCodes[5] = '{6'h00, 6'h02, 6'h3F, 6'h10, 6'h28};
    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    nChecks++;
    if (outValid !== 0 || result !== '0 || resultWe !== 0 || tOut !== 0 || tWe !== 0 || illegal !== 0) begin
      nFails++;
      $display("FAIL R11: act vld=%b res=%h rWe=%b t=%b tWe=%b ill=%b exp all zero",
               outValid, result, resultWe, tOut, tWe, illegal);
    end
    @(negedge clk);
    rstN = 1'b1;
    // R2..R7: every legal code, patterns, both T values
    foreach (codes[i]) begin
      foreach (pats[j]) begin
        for (int t = 0; t < 2; t++) begin
          applyOp({4'b0100, 4'(j), 2'b00, codes[i]}, pats[j], 1'(t));
        end
      end
      idleCycle();
      idleCycle();
    end
    // R8: undefined codes
    foreach (badCodes[i]) begin
      applyOp({4'b0100, 4'h3, 2'b00, badCodes[i]}, 32'hDEAD_BEEF, 1'b1);
    end
    idleCycle();
    // R1: same low bits, other group
    applyOp(16'h0004, 32'h8000_0001, 1'b0);
    applyOp(16'h3025, 32'h8000_0001, 1'b1);
    applyOp(16'hF011, 32'hFFFF_FFFF, 1'b1);
    // R10: back-to-back then idle hold
    applyOp(16'h4A29, 32'hCAFE_F00D, 1'b0);
    idleCycle();
    idleCycle();
    applyOp(16'h4115, 32'h0000_0000, 1'b1);
    idleCycle();
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    finishRun();
  end
endmodule